// File: doc/BRIEF.md
# Energy Dispersal Descrambler

This block follows the block decoder on a satellite transport receive path and undoes the energy-dispersal scrambling that the transmitter applied to MPEG-2 transport packets. Bytes arrive one per valid cycle with a start-of-packet marker on each sync byte. A packet carries either 188 bytes, or 204 bytes where the last 16 are block-code check bytes. Upstream logic locates the packets. This block only counts byte positions from each start-of-packet marker.

A 15-stage pseudo-random generator with feedback polynomial 1 + x^14 + x^15 produces eight bits per byte. The generator is loaded with a fixed seed whenever a packet starts with the inverted sync value 0xB8. The transmitter marks the first packet of every eight-packet group this way. Each payload byte is XORed with the generator byte, and the inverted sync is put back to 0x47. The other sync bytes and the check bytes are never XORed. A bypass input passes every byte unchanged, and a second input removes the check bytes from the output stream. A status output stays high until the first inverted sync has been seen.

Top module: `energy_descrambler`

## Requirements
- R1: Every accepted byte leaves exactly one clock cycle after it enters. The output start-of-packet marker is set on the same bytes as at the input, and no output is valid in a cycle after one with no valid input.
- R2: While reset is held low at a clock edge and after that edge, out_valid is 0 and out_unsynced is 1.
- R3: Descrambling uses stages 1..15 loaded with 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0 on reload. Each step outputs stage14 XOR stage15, shifts the stages up by one, and feeds that bit into stage 1. The first output bit is the MSB of the byte. With all-zero payload input after a reload, the first two payload bytes out are 0x03 and 0xF6.
- R4: A byte flagged as start of packet that equals 0xB8 reloads the generator without advancing it, and leaves as 0x47 when bypass is 0.
- R5: A start-of-packet byte other than 0xB8 leaves unchanged, while the generator advances eight steps during it.
- R6: Bytes at positions 188 to 203 after the sync byte (position 0) leave unchanged and do not advance the generator.
- R7: When drop_parity is 1, bytes at positions 188 to 203 produce no valid output cycle. All other bytes are still delivered.
- R8: Until the first 0xB8 start-of-packet byte, all bytes leave unchanged and out_unsynced is 1. out_unsynced falls in the same cycle that the restored sync byte is output, and stays 0 until reset.
- R9: With bypass at 1, every byte, including 0xB8, leaves unchanged. The generator still reloads and advances as in R4 and R5, so payload after bypass returns to 0 is descrambled in step.
- R10: A 0xB8 start-of-packet byte reloads the generator wherever it appears, regardless of how many packets have passed since the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_i | input | 1 | 1: pass all bytes unchanged |
| drop_parity_i | input | 1 | 1: suppress check bytes at positions 188..203 |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is a packet's sync byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is a packet's sync byte |
| out_data | output | 8 | Descrambled byte |
| out_unsynced | output | 1 | 1 until the first inverted sync is seen |

## Verification
The bench uses all-zero payload after a reload to pin the absolute generator sequence (0x03, 0xF6). It then feeds pseudo-random payload through full eight-packet groups to tell apart generator stepping on normal sync bytes from no stepping on them. Packets with 16 check bytes, sent with and without dropping, separate payload from check-byte handling. Bypass in the middle of a group shows that the generator keeps running, and a reload before the eighth packet shows that reloading does not depend on a group counter. Unlocked traffic and inserted idle cycles check the pass-through state and the alignment of valid and start-of-packet.

// File: rtl/edd_pkg.sv
// Shared constants and types for the energy dispersal descrambler.
package edd_pkg;
    localparam logic [7:0] SYNC_NORMAL = 8'h47;
    localparam logic [7:0] SYNC_INVERT = 8'hB8;
    localparam int PRBS_W     = 15;
    localparam int PRBS_TAP_A = 14;
    localparam int PRBS_TAP_B = 15;
    // Stage 1 in bit 0: stages 1,4,6,8 set.
    localparam logic [PRBS_W-1:0] PRBS_SEED = 15'h00A9;

    typedef enum logic [1:0] {
        BC_SYNC   = 2'd0,
        BC_PAY    = 2'd1,
        BC_PARITY = 2'd2
    } byte_cls_e;
endpackage

// File: rtl/edd_prbs.sv
// Byte-wide Fibonacci PRBS generator.
// Presents the next BITS output bits (first bit in MSB) from the current state.
// load_i restores SEED, step_i advances BITS steps. load_i wins.
// Assumes TAP_A < TAP_B <= W; stage 1 is bit 0.
module edd_prbs #(
    parameter int W     = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 15,
    parameter int BITS  = 8,
    parameter logic [W-1:0] SEED = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    output logic [BITS-1:0] bits_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] run_s;
    logic [W-1:0] state_after;
    logic         fb;

    // Unroll BITS shift steps to form the output byte and the advanced state.
    always_comb begin
        run_s  = state_q;
        bits_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < BITS; i++) begin
            fb                 = run_s[TAP_A-1] ^ run_s[TAP_B-1];
            bits_o[BITS-1-i]   = fb;
            run_s              = {run_s[W-2:0], fb};
        end
        state_after = run_s;
    end

    // Hold, reload or advance the generator state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load_i) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= state_after;
        end
    end
endmodule

// File: rtl/edd_pos.sv
// Byte position tracker within a transport packet.
// Classifies the current input byte as sync, payload or check byte.
// Assumes in-packet positions start at 0 on the start-of-packet byte.
// Bytes seen before any start-of-packet marker count as check bytes.
module edd_pos
    import edd_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int PAR_LEN = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid_i,
    input  logic      sop_i,
    output byte_cls_e cls_o
);
    localparam int TOTAL = PKT_LEN + PAR_LEN;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST    = CW'(TOTAL);
    localparam logic [CW-1:0] PAY_END = CW'(PKT_LEN);

    logic [CW-1:0] idx_q;
    logic [CW-1:0] idx_cur;

    // Position of the current byte, saturating past the packet end.
    always_comb begin
        if (sop_i) begin
            idx_cur = '0;
        end else if (idx_q == LAST) begin
            idx_cur = LAST;
        end else begin
            idx_cur = idx_q + 1'b1;
        end
    end

    // Map the position to a byte class.
    always_comb begin
        if (sop_i) begin
            cls_o = BC_SYNC;
        end else if (idx_cur < PAY_END) begin
            cls_o = BC_PAY;
        end else begin
            cls_o = BC_PARITY;
        end
    end

    // Remember the position of the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= LAST;
        end else if (valid_i) begin
            idx_q <= idx_cur;
        end
    end
endmodule

// File: rtl/energy_descrambler.sv
// Energy dispersal descrambler for MPEG-2 transport streams.
// Reloads the PRBS on an inverted sync byte and restores that byte to 0x47.
// XORs payload bytes with the PRBS byte and passes sync and check bytes.
// Has a one-cycle registered latency.
// Assumes upstream framing flags each sync byte with in_sop.
module energy_descrambler
    import edd_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int PAR_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass_i,
    input  logic       drop_parity_i,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic       out_sop,
    output logic [7:0] out_data,
    output logic       out_unsynced
);
    byte_cls_e  cls;
    logic [7:0] prbs_byte;
    logic       is_inv;
    logic       prbs_step;
    logic       locked_q;
    logic [7:0] data_d;
    logic       valid_d;

    edd_pos #(
        .PKT_LEN (PKT_LEN),
        .PAR_LEN (PAR_LEN)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .sop_i   (in_sop),
        .cls_o   (cls)
    );

    edd_prbs #(
        .W     (PRBS_W),
        .TAP_A (PRBS_TAP_A),
        .TAP_B (PRBS_TAP_B),
        .BITS  (8),
        .SEED  (PRBS_SEED)
    ) u_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (is_inv),
        .step_i (prbs_step),
        .bits_o (prbs_byte)
    );

    // Decode the reload condition and the generator advance.
    always_comb begin
        is_inv    = in_valid && (cls == BC_SYNC) && (in_data == SYNC_INVERT);
        prbs_step = in_valid && !is_inv && (cls != BC_PARITY);
    end

    // Form the output byte and its valid flag.
    always_comb begin
        data_d = in_data;
        if (!bypass_i) begin
            if (is_inv) begin
                data_d = SYNC_NORMAL;
            end else if (locked_q && (cls == BC_PAY)) begin
                data_d = in_data ^ prbs_byte;
            end
        end
        valid_d = in_valid && !(drop_parity_i && (cls == BC_PARITY));
    end

    // Set the lock flag on the first inverted sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (is_inv) begin
            locked_q <= 1'b1;
        end
    end

    // Register the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= valid_d;
            out_sop   <= valid_d && in_sop;
            out_data  <= data_d;
        end
    end

    assign out_unsynced = !locked_q;
endmodule

// File: rtl/energy_descrambler_chk.sv
// Port-level checker for energy_descrambler, attached by bind.
module energy_descrambler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bypass_i,
    input logic       in_valid,
    input logic       in_sop,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_sop,
    input logic [7:0] out_data,
    input logic       out_unsynced
);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_sop_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (out_valid && out_sop));

    a_r4_sync_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_data == 8'hB8 && !bypass_i) |=> (out_data == 8'h47));

    a_r5_sync_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_data != 8'hB8) |=> (out_data == $past(in_data)));

    a_r8_lock_on_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_data == 8'hB8) |=> !out_unsynced);

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !out_unsynced |=> !out_unsynced);

    a_r8_pass_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (out_unsynced && in_valid && !(in_sop && in_data == 8'hB8)) |=> (out_data == $past(in_data)));

    a_r9_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass_i) |=> (out_data == $past(in_data)));
endmodule

bind energy_descrambler energy_descrambler_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bypass_i     (bypass_i),
    .in_valid     (in_valid),
    .in_sop       (in_sop),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_sop      (out_sop),
    .out_data     (out_data),
    .out_unsynced (out_unsynced)
);

// File: tb/energy_descrambler_test.sv
`timescale 1ns/1ps
module energy_descrambler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bypass = 1'b0;
    logic       drop = 1'b0;
    logic       iv = 1'b0;
    logic       isop = 1'b0;
    logic [7:0] id = 8'h00;
    logic       ov, osop, ounsync;
    logic [7:0] od;

    always #10 clk = ~clk;

    energy_descrambler uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bypass_i      (bypass),
        .drop_parity_i (drop),
        .in_valid      (iv),
        .in_sop        (isop),
        .in_data       (id),
        .out_valid     (ov),
        .out_sop       (osop),
        .out_data      (od),
        .out_unsynced  (ounsync)
    );

    typedef struct {
        logic [7:0] d;
        logic       sop;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_d[$];
    logic       got_s[$];
    int         vec = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic [15:1] m_s;
    bit         m_lock = 1'b0;
    logic [7:0] lcg = 8'h5A;
    localparam logic [1:15] SEED_BITS = 15'b100101010000000;

    // Capture every valid output byte.
    always @(negedge clk) begin
        if (rst_n && ov) begin
            got_d.push_back(od);
            got_s.push_back(osop);
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        vec++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, want);
        end
    endtask

    task automatic m_seed();
        for (int i = 1; i <= 15; i++) m_s[i] = SEED_BITS[i];
    endtask

    function automatic logic [7:0] m_run();
        logic [7:0] b;
        logic       o;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            o = m_s[14] ^ m_s[15];
            b = {b[6:0], o};
            m_s = {m_s[14:1], o};
        end
        return b;
    endfunction

    function automatic logic [7:0] next_raw();
        lcg = lcg * 8'd29 + 8'd47;
        return lcg;
    endfunction

    task automatic put(input logic [7:0] d, input logic sop, input int gap);
        @(negedge clk);
        iv = 1'b1; isop = sop; id = d;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            iv = 1'b0; isop = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            iv = 1'b0; isop = 1'b0;
        end
    endtask

    task automatic xmit_pkt(input logic [7:0] sync_raw, input int npar, input int gap,
                            input bit zero_pay, input string tag);
        exp_t       e;
        logic [7:0] raw;
        logic [7:0] k;
        if (sync_raw == 8'hB8) begin
            m_seed();
            m_lock = 1'b1;
        end else begin
            void'(m_run());
        end
        e.d = (bypass || sync_raw != 8'hB8) ? sync_raw : 8'h47;
        e.sop = 1'b1; e.tag = {tag, " sync"};
        exp_q.push_back(e);
        put(sync_raw, 1'b1, gap);
        for (int i = 1; i < 188; i++) begin
            raw = zero_pay ? 8'h00 : next_raw();
            k = m_run();
            e.d = (m_lock && !bypass) ? (raw ^ k) : raw;
            e.sop = 1'b0; e.tag = {tag, " payload"};
            exp_q.push_back(e);
            put(raw, 1'b0, (i % 61 == 0) ? gap : 0);
        end
        for (int i = 0; i < npar; i++) begin
            raw = next_raw();
            e.d = raw; e.sop = 1'b0; e.tag = "R6 check byte";
            if (!drop) exp_q.push_back(e);
            put(raw, 1'b0, 0);
        end
    endtask

    task automatic drain_cmp(input string tag);
        idle(3);
        check({tag, " byte count"}, got_d.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_d.size(); i++) begin
            check(exp_q[i].tag, got_d[i], exp_q[i].d);
            check("R1 sop alignment", got_s[i], exp_q[i].sop);
        end
        exp_q.delete(); got_d.delete(); got_s.delete();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 out_valid in reset", ov, 0);
        check("R2 out_unsynced in reset", ounsync, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 out_valid after reset", ov, 0);
        check("R2 out_unsynced after reset", ounsync, 1);
    endtask

    task automatic t_latency();
        @(negedge clk);
        iv = 1'b1; isop = 1'b1; id = 8'h47;
        @(negedge clk);
        iv = 1'b0; isop = 1'b0;
        check("R1 valid one cycle later", ov, 1);
        check("R1 sop one cycle later", osop, 1);
        check("R1 data one cycle later", od, 8'h47);
        @(negedge clk);
        check("R1 no extra valid", ov, 0);
        got_d.delete(); got_s.delete();
        void'(m_run());
    endtask

    task automatic t_unsynced();
        xmit_pkt(8'h47, 0, 0, 1'b0, "R8 unlocked");
        xmit_pkt(8'h47, 16, 2, 1'b0, "R8 unlocked");
        check("R8 flag before inverted sync", ounsync, 1);
        drain_cmp("R8");
    endtask

    task automatic t_anchor();
        xmit_pkt(8'hB8, 0, 0, 1'b1, "R3 zero payload");
        idle(3);
        check("R4 restored sync", got_d[0], 8'h47);
        check("R3 first prbs byte", got_d[1], 8'h03);
        check("R3 second prbs byte", got_d[2], 8'hF6);
        check("R8 flag after inverted sync", ounsync, 0);
        drain_cmp("R3");
    endtask

    task automatic t_group();
        xmit_pkt(8'hB8, 0, 1, 1'b0, "R4 group head");
        for (int p = 1; p < 8; p++) xmit_pkt(8'h47, 0, p % 2, 1'b0, "R5 group member");
        drain_cmp("R5");
    endtask

    task automatic t_parity();
        drop = 1'b0;
        xmit_pkt(8'hB8, 16, 0, 1'b0, "R6 head");
        xmit_pkt(8'h47, 16, 1, 1'b0, "R6 member");
        drain_cmp("R6");
        drop = 1'b1;
        xmit_pkt(8'h47, 16, 0, 1'b0, "R7 member");
        xmit_pkt(8'h47, 16, 2, 1'b0, "R7 member");
        drain_cmp("R7");
        drop = 1'b0;
    endtask

    task automatic t_bypass();
        bypass = 1'b1;
        xmit_pkt(8'hB8, 0, 0, 1'b0, "R9 bypass head");
        xmit_pkt(8'h47, 0, 0, 1'b0, "R9 bypass member");
        idle(2);
        bypass = 1'b0;
        xmit_pkt(8'h47, 0, 0, 1'b0, "R9 resumed member");
        drain_cmp("R9");
    endtask

    task automatic t_midreload();
        xmit_pkt(8'hB8, 0, 0, 1'b0, "R10 head");
        xmit_pkt(8'h47, 0, 0, 1'b0, "R10 member");
        xmit_pkt(8'h47, 0, 0, 1'b0, "R10 member");
        xmit_pkt(8'hB8, 0, 1, 1'b0, "R10 early reload");
        xmit_pkt(8'h47, 0, 0, 1'b0, "R10 after reload");
        drain_cmp("R10");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_unsynced();
        t_anchor();
        t_group();
        t_parity();
        t_bypass();
        t_midreload();
        check("R8 flag stays low", ounsync, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule